// File: doc/BRIEF.md
# Cascaded Timer Divisor Pair Search

This block turns a requested period into a pair of divisors for two chained 16-bit counters. The request and the base clock period are given in the same time unit. The block searches over clock cycles for two factors whose product, times the base period, comes closest to the request under a chosen rounding policy. It returns both divisors in counter-load encoding, where 65536 is written as 0. It also returns the period that pair actually gives, with a one-cycle done pulse.

Some callers already hold a divisor pair that gives the exact request. In that case the block accepts that pair one cycle after start and runs no search. Otherwise the search tests one candidate pair per clock. The caller pulses start once and waits for done. The inputs are captured on the start edge, so they may change while the search runs.

Top module: `cascade_div_search`

## Requirements
- R1: After reset, done and busy are low and div_a, div_b and period_out are 0.
- R2: A current divisor input of 0 means 65536. Fast path: both current divisors are at least 2, and a×b×base equals the request exactly, with no overflow. Then done rises one cycle after start. div_a and div_b repeat the input encodings, period_out equals the request, and busy stays low.
- R3: A current divisor below 2 (for example 1) rules out the fast path, even when the product matches. The full search then runs.
- R4: Let ratio be request/base, rounded down. The outer factor starts at ratio/65536, clamped to at least 2. It continues while outer×outer ≤ ratio+outer and outer ≤ 65536. For each outer value, the inner factor starts at ratio/outer and continues while outer×inner ≤ ratio+outer+1 and inner ≤ 65536. Inner rises by one per clock, and outer rises by one when its inner run ends.
- R5: The search keeps two trackers. One holds the largest candidate period that is not above the request; it starts at 0. The other holds the smallest candidate period that is not below the request; it starts at all ones. On a tie, the first pair found is kept. A tracker that is never updated holds the pair 0/0.
- R6: round_sel = 1 (up) selects the not-below tracker.
- R7: round_sel = 2 (down) selects the not-above tracker.
- R8: round_sel = 0 or 3 (nearest) selects the not-below tracker only when its tracked period minus the request is strictly less than the request minus the not-above tracked period. An equal distance selects the not-above pair.
- R9: After a search, period_out is the low 32 bits of outer×inner×base for the selected pair. Each divisor output is the low 16 bits of its factor, so 65536 appears as 0. The outputs change only in the cycle that done is high.
- R10: busy is high from the cycle after an accepted start until done. done is high for exactly one cycle. The latency is: 2 cycles, plus 1 per outer test, plus 1 per inner test (passing or failing), plus 1 for the result.
- R11: A start while busy is ignored. It changes neither the result nor the timing of the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (honoured only when idle) |
| req_period | input | 32 | Requested period |
| base_period | input | 16 | Period of one base clock tick, same unit |
| cur_div_a | input | 16 | Current first divisor, 0 means 65536 |
| cur_div_b | input | 16 | Current second divisor, 0 means 65536 |
| round_sel | input | 2 | 0/3 nearest, 1 up, 2 down |
| div_a | output | 16 | Result first divisor, counter-load encoding |
| div_b | output | 16 | Result second divisor, counter-load encoding |
| period_out | output | 32 | Period given by the result pair |
| done | output | 1 | One-cycle result strobe |
| busy | output | 1 | Search in progress |

## Verification
The bench aims at the tie under nearest rounding, where a design that compares with less-or-equal would return the larger pair. It also aims at the 65536 boundary. There, a design that drops the 17th bit would emit a wrong load value, or would stop its loops one step early and miss the best pair. A request that no pair can reach from above leaves the upper tracker empty. That case catches designs that seed the trackers wrongly or pick the wrong one. A divisor of 1 in an otherwise exact pair shows whether the fast-path range check is present. A start pulse in mid-search would shift the done cycle in a design that does not ignore it.

// File: rtl/cascade_div_search.sv
module cascade_div_search #(
  parameter int DIV_W  = 16,
  parameter int BASE_W = 16,
  parameter int REQ_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REQ_W-1:0]  req_period,
  input  logic [BASE_W-1:0] base_period,
  input  logic [DIV_W-1:0]  cur_div_a,
  input  logic [DIV_W-1:0]  cur_div_b,
  input  logic [1:0]        round_sel,
  output logic [DIV_W-1:0]  div_a,
  output logic [DIV_W-1:0]  div_b,
  output logic [REQ_W-1:0]  period_out,
  output logic              done,
  output logic              busy
);
  localparam int CW = DIV_W + 2;
  localparam int WW = 2 * CW + BASE_W + 2;
  localparam logic [WW-1:0] DMAX = WW'(1) << DIV_W;

  typedef enum logic [2:0] {S_IDLE, S_RATIO, S_OUTER, S_INNER, S_DONE} st_t;
  st_t st;

  logic [REQ_W-1:0]  req_q, ratio, lo_ns, hi_ns;
  logic [BASE_W-1:0] base_q;
  logic [1:0]        mode_q;
  logic [CW-1:0]     outer, inner, lo_a, lo_b, hi_a, hi_b;

  assign busy = (st != S_IDLE);

  // fast-path acceptance of the caller's pair
  logic [CW-1:0] in_a, in_b;
  logic fast;
  assign in_a = (cur_div_a == '0) ? CW'(DMAX) : CW'(cur_div_a);
  assign in_b = (cur_div_b == '0) ? CW'(DMAX) : CW'(cur_div_b);
  assign fast = (in_a >= CW'(2)) && (in_b >= CW'(2)) &&
                (WW'(in_a) * WW'(in_b) * WW'(base_period) == WW'(req_period));

  // one divider shared by the ratio step and each inner start
  logic [REQ_W-1:0] num, den, quo, quo_hi;
  assign num    = (st == S_RATIO) ? req_q : ratio;
  assign den    = (st == S_RATIO) ? ((base_q == '0) ? REQ_W'(1) : REQ_W'(base_q))
                                  : REQ_W'(outer);
  assign quo    = num / den;
  assign quo_hi = quo >> DIV_W;

  // loop bounds and candidate evaluation
  logic [WW-1:0] o_w, i_w, r_w, ns;
  logic outer_ok, inner_ok, take_lo, take_hi;
  assign o_w      = WW'(outer);
  assign i_w      = WW'(inner);
  assign r_w      = WW'(ratio);
  assign outer_ok = (o_w * o_w <= r_w + o_w) && (o_w <= DMAX);
  assign inner_ok = (o_w * i_w <= r_w + o_w + WW'(1)) && (i_w <= DMAX);
  assign ns       = o_w * i_w * WW'(base_q);
  assign take_lo  = (ns <= WW'(req_q)) && (ns > WW'(lo_ns));
  assign take_hi  = (ns >= WW'(req_q)) && (ns < WW'(hi_ns));

  // rounding choice
  logic pick_hi;
  logic [CW-1:0] sel_a, sel_b;
  assign pick_hi = (mode_q == 2'd1) ? 1'b1 :
                   (mode_q == 2'd2) ? 1'b0 :
                   ((hi_ns - req_q) < (req_q - lo_ns));
  assign sel_a = pick_hi ? hi_a : lo_a;
  assign sel_b = pick_hi ? hi_b : lo_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      req_q <= '0; base_q <= '0; mode_q <= '0; ratio <= '0;
      outer <= '0; inner <= '0;
      lo_ns <= '0; hi_ns <= '0;
      lo_a <= '0; lo_b <= '0; hi_a <= '0; hi_b <= '0;
      div_a <= '0; div_b <= '0; period_out <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          req_q  <= req_period;
          base_q <= base_period;
          mode_q <= round_sel;
          if (fast) begin
            div_a      <= cur_div_a;
            div_b      <= cur_div_b;
            period_out <= req_period;
            done       <= 1'b1;
          end else begin
            lo_ns <= '0; hi_ns <= '1;
            lo_a <= '0; lo_b <= '0; hi_a <= '0; hi_b <= '0;
            st <= S_RATIO;
          end
        end
        S_RATIO: begin
          ratio <= quo;
          outer <= (quo_hi < REQ_W'(2)) ? CW'(2) : CW'(quo_hi);
          st    <= S_OUTER;
        end
        S_OUTER: begin
          if (outer_ok) begin
            inner <= CW'(quo);
            st    <= S_INNER;
          end else begin
            st <= S_DONE;
          end
        end
        S_INNER: begin
          if (inner_ok) begin
            if (take_lo) begin
              lo_ns <= REQ_W'(ns); lo_a <= outer; lo_b <= inner;
            end
            if (take_hi) begin
              hi_ns <= REQ_W'(ns); hi_a <= outer; hi_b <= inner;
            end
            inner <= inner + CW'(1);
          end else begin
            outer <= outer + CW'(1);
            st    <= S_OUTER;
          end
        end
        S_DONE: begin
          div_a      <= DIV_W'(sel_a);
          div_b      <= DIV_W'(sel_b);
          period_out <= REQ_W'(WW'(sel_a) * WW'(sel_b) * WW'(base_q));
          done       <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(div_a) && $stable(div_b) && $stable(period_out)));

  p_fast_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && fast) |=> (done && !busy && period_out == $past(req_period)));

  p_outer_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INNER) |-> (outer >= CW'(2) && WW'(outer) <= DMAX));

  p_trackers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INNER) |-> (lo_ns <= req_q && hi_ns >= req_q));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(req_q) && $stable(mode_q) && $stable(base_q)));
endmodule

// File: tb/cascade_div_search_test.sv
`timescale 1ns/1ps
module cascade_div_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_period = '0;
  logic [15:0] base_period = '0;
  logic [15:0] cur_div_a = '0;
  logic [15:0] cur_div_b = '0;
  logic [1:0]  round_sel = '0;
  logic [15:0] div_a, div_b;
  logic [31:0] period_out;
  logic        done, busy;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  cascade_div_search uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_period(req_period),
    .base_period(base_period), .cur_div_a(cur_div_a), .cur_div_b(cur_div_b),
    .round_sel(round_sel), .div_a(div_a), .div_b(div_b),
    .period_out(period_out), .done(done), .busy(busy)
  );

  task automatic check(input string rq, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // behavioural reference built from the requirements
  task automatic model(input longint req, input longint base, input longint ca,
                       input longint cb, input int mode,
                       output longint ea, output longint eb, output longint ep,
                       output int lat);
    longint a, b, r, o, i, ns, lo, hi, lo_a, lo_b, hi_a, hi_b, sa, sb;
    bit up;
    a = (ca == 0) ? 65536 : ca;
    b = (cb == 0) ? 65536 : cb;
    if (a >= 2 && b >= 2 && a * b * base == req) begin
      ea = ca; eb = cb; ep = req; lat = 1;
      return;
    end
    r = req / ((base == 0) ? 1 : base);
    o = r / 65536;
    if (o < 2) o = 2;
    lo = 0; hi = 64'hFFFF_FFFF;
    lo_a = 0; lo_b = 0; hi_a = 0; hi_b = 0;
    lat = 2;
    forever begin
      lat++;
      if (!(o * o <= r + o && o <= 65536)) break;
      i = r / o;
      forever begin
        lat++;
        if (!(o * i <= r + o + 1 && i <= 65536)) break;
        ns = o * i * base;
        if (ns <= req && ns > lo) begin lo = ns; lo_a = o; lo_b = i; end
        if (ns >= req && ns < hi) begin hi = ns; hi_a = o; hi_b = i; end
        i++;
      end
      o++;
    end
    lat++;
    if (mode == 1) up = 1'b1;
    else if (mode == 2) up = 1'b0;
    else up = ((hi - req) < (req - lo));
    sa = up ? hi_a : lo_a;
    sb = up ? hi_b : lo_b;
    ea = sa & 64'hFFFF;
    eb = sb & 64'hFFFF;
    ep = (sa * sb * base) & 64'hFFFF_FFFF;
  endtask

  // poke=1 pulses start again while busy (R11)
  task automatic run_op(input longint rq, input longint bs, input longint ca,
                        input longint cb, input int md, input bit poke,
                        input string tag);
    longint ea, eb, ep;
    int lat;
    model(rq, bs, ca, cb, md, ea, eb, ep, lat);
    @(negedge clk);
    req_period = rq[31:0]; base_period = bs[15:0];
    cur_div_a = ca[15:0]; cur_div_b = cb[15:0]; round_sel = md[1:0];
    start = 1'b1;
    for (int c = 1; c <= lat + 1; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && c == 1 && lat > 3) begin
        start = 1'b1;
        req_period = rq[31:0] + 32'd5;
        round_sel = 2'd1 - md[1:0];
      end
      check({tag, " R10 done"}, longint'(done), longint'(c == lat));
      check({tag, " R10 busy"}, longint'(busy), longint'(c < lat));
      if (c == lat) begin
        check({tag, " R9 div_a"}, longint'(div_a), ea);
        check({tag, " R9 div_b"}, longint'(div_b), eb);
        check({tag, " R9 period"}, longint'(period_out), ep);
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", longint'(done), 0);
    check("R1 busy", longint'(busy), 0);
    check("R1 div_a", longint'(div_a), 0);
    check("R1 period", longint'(period_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", longint'(busy), 0);

    // R2 fast path, plain and with 0 read as 65536
    run_op(6000, 100, 6, 10, 0, 1'b0, "R2 exact pair");
    run_op(131072, 1, 0, 2, 0, 1'b0, "R2 zero divisor");
    // R3 divisor of 1 forces a search
    run_op(6000, 1, 1, 6000, 0, 1'b0, "R3 reject one");
    // R6 R7 R8 rounding on request 7: below 6 (2x3), above 8 (2x4), tie
    run_op(7, 1, 5, 5, 1, 1'b0, "R6 round up");
    run_op(7, 1, 5, 5, 2, 1'b0, "R7 round down");
    run_op(7, 1, 5, 5, 0, 1'b0, "R8 nearest tie");
    run_op(7, 1, 5, 5, 3, 1'b0, "R8 code three");
    // R4/R5 larger searches
    run_op(250001, 10, 3, 3, 0, 1'b0, "R4/R5 mid");
    run_op(12345678, 1000, 0, 0, 1, 1'b0, "R4/R5 base1000");
    run_op(0, 3, 0, 0, 0, 1'b0, "R5 empty trackers");
    // R9 boundary 65536 and an empty upper tracker
    run_op(64'hFFFF_FFF0, 1, 7, 7, 2, 1'b0, "R9 edge down");
    run_op(64'hFFFF_FFF0, 1, 7, 7, 1, 1'b0, "R5 edge up");
    run_op(64'hFFFF_FFF0, 1, 7, 7, 0, 1'b0, "R8 edge nearest");
    // R11 start while busy ignored
    run_op(99991, 7, 2, 2, 2, 1'b1, "R11 poke");
    run_op(5000, 3, 9, 9, 0, 1'b1, "R11 poke nearest");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule